// File: doc/BRIEF.md
# One-Hot to Binary Encoder

This block turns a one-hot code word into the binary index of its active bit. Code value k is carried by bit k alone being active, so bit 0 (the LSB) stands for value 0. A parameter sets whether an input bit counts as active when high or when low. The input width is a parameter that may range from 2 to 999, and the index is as wide as it must be to hold the largest bit position.

There are two decoding styles, and a parameter picks one at elaboration. In flat mode the whole word is judged at once. Only a word with exactly one active bit is accepted, and any other word raises the error flag. In priority mode the bits are scanned one at a time in a configurable direction (LSB first or MSB first), and the first active bit found sets the index. Here the error flag means only that no bit was active. When the enable input is low, the index is forced to zero and the error flag is cleared.

Both outputs are registered. A code word presented at one rising clock edge shows up on the outputs after that edge, and the reset is asynchronous and active low.

Top module: `onehot_bin_enc`

## Requirements
- R1: With enable high and exactly one active bit at position k, binOut equals k and errOut is 0.
- R2: When ACTIVE_HIGH is 0, a bit counts as active when it is 0. The active-low encoder returns the same results for the inverted word as the active-high encoder returns for the original word.
- R3: In flat mode (PRIORITY = 0), a word with no active bit gives errOut = 1 and binOut = 0.
- R4: In flat mode, a word with two or more active bits gives errOut = 1 and binOut = 0.
- R5: In priority mode with MSB_FIRST = 0, binOut is the lowest active position and errOut is 0 whenever at least one bit is active.
- R6: In priority mode with MSB_FIRST = 1, binOut is the highest active position and errOut is 0 whenever at least one bit is active.
- R7: In priority mode, a word with no active bit gives errOut = 1 and binOut = 0.
- R8: While enable is low, the next outputs are binOut = 0 and errOut = 0, whatever the code word is.
- R9: While rst_n is low, binOut and errOut are 0.
- R10: Outputs change exactly one clock edge after the inputs are sampled. Each result is visible after the rising edge at which its inputs were present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| codeIn | input | WIDTH | One-hot code word, in the polarity set by ACTIVE_HIGH |
| enable | input | 1 | High to convert; low forces the outputs to zero |
| binOut | output | IDX_W | Registered binary index of the active bit |
| errOut | output | 1 | Registered error flag |

## Verification
The bench drives the same logical pattern into four variants at once:
- flat active-high
- flat active-low
- priority LSB-first active-high
- priority MSB-first active-low

It walks a single active bit across every position, including both ends. A design that mishandles either end, or decodes an index bit wrongly, reports a wrong index at that position.

The empty word and several multi-bit words, including the all-active word, separate the modes:
- A flat encoder that ORs indices without a multi-bit check returns a garbage index with no error.
- A priority encoder scanning in the wrong direction returns the opposite end.
- An inverted polarity shows up as errors on valid words.

Words presented with enable low, directly after valid and invalid words, expose an encoder that holds its last result or leaves the error flag set.

// File: rtl/onehot_enc_pkg.sv
package onehot_enc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;   // capture the decoded index and error
    logic clearResult;  // force the result register to zero
  } encStrobe_t;
endpackage

// File: rtl/ohe_control.sv
module ohe_control
  import onehot_enc_pkg::*;
(
  input  logic       enable,
  output encStrobe_t strobe
);
  always_comb begin
    strobe.loadResult  = enable;
    strobe.clearResult = !enable;
  end
endmodule

// File: rtl/ohe_datapath.sv
module ohe_datapath
  import onehot_enc_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit PRIORITY    = 1'b0,
  parameter bit MSB_FIRST   = 1'b0,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] codeIn,
  input  encStrobe_t       strobe,
  output logic [IDX_W-1:0] binQ,
  output logic             errQ
);
  logic [WIDTH-1:0] activeBits;
  logic [IDX_W-1:0] nextIdx;
  logic             nextErr;
  logic             noneActive;

  // Polarity normalisation
  generate
    if (ACTIVE_HIGH) begin : g_polHigh
      assign activeBits = codeIn;
    end else begin : g_polLow
      assign activeBits = ~codeIn;
    end
  endgenerate

  assign noneActive = ~|activeBits;

  generate
    if (PRIORITY) begin : g_prio
      logic [IDX_W-1:0] scanIdx;
      logic             found;
      if (MSB_FIRST) begin : g_msbFirst
        always_comb begin
          scanIdx = '0;
          found   = 1'b0;
          for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!found && activeBits[i]) begin
              scanIdx = IDX_W'(i);
              found   = 1'b1;
            end
          end
        end
      end else begin : g_lsbFirst
        always_comb begin
          scanIdx = '0;
          found   = 1'b0;
          for (int i = 0; i < WIDTH; i++) begin
            if (!found && activeBits[i]) begin
              scanIdx = IDX_W'(i);
              found   = 1'b1;
            end
          end
        end
      end
      assign nextIdx = scanIdx;
      assign nextErr = !found;
    end else begin : g_flat
      logic [IDX_W-1:0] orIdx;
      logic             multiActive;
      // Each index bit is the OR of all positions carrying that bit
      always_comb begin
        orIdx = '0;
        for (int i = 0; i < WIDTH; i++) begin
          if (activeBits[i]) orIdx = orIdx | IDX_W'(i);
        end
      end
      assign multiActive = |(activeBits & (activeBits - WIDTH'(1)));
      assign nextErr     = noneActive | multiActive;
      assign nextIdx     = nextErr ? '0 : orIdx;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      binQ <= '0;
      errQ <= 1'b0;
    end else if (strobe.clearResult) begin
      binQ <= '0;
      errQ <= 1'b0;
    end else if (strobe.loadResult) begin
      binQ <= nextIdx;
      errQ <= nextErr;
    end
  end
endmodule

// File: rtl/onehot_bin_enc.sv
module onehot_bin_enc
  import onehot_enc_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit PRIORITY    = 1'b0,
  parameter bit MSB_FIRST   = 1'b0,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] codeIn,
  input  logic             enable,
  output logic [IDX_W-1:0] binOut,
  output logic             errOut
);
  encStrobe_t strobe;

  ohe_control u_control (
    .enable (enable),
    .strobe (strobe)
  );

  ohe_datapath #(
    .WIDTH       (WIDTH),
    .ACTIVE_HIGH (ACTIVE_HIGH),
    .PRIORITY    (PRIORITY),
    .MSB_FIRST   (MSB_FIRST)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .codeIn (codeIn),
    .strobe (strobe),
    .binQ   (binOut),
    .errQ   (errOut)
  );
endmodule

// File: rtl/onehot_bin_enc_sva.sv
module onehot_bin_enc_sva #(
  parameter int WIDTH       = 10,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit PRIORITY    = 1'b0,
  parameter bit MSB_FIRST   = 1'b0,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] codeIn,
  input logic             enable,
  input logic [IDX_W-1:0] binOut,
  input logic             errOut
);
  logic [WIDTH-1:0] act;
  assign act = ACTIVE_HIGH ? codeIn : ~codeIn;

  // R8: disabled cycle clears both outputs
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (binOut == '0 && !errOut));

  // R1: single active bit is never flagged
  assert_single_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $countones(act) == 1) |=> !errOut);

  // R3 R7: an error always comes with a zero index
  assert_err_zero_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    errOut |-> binOut == '0);

  // R9: outputs are zero while in reset
  always_comb begin
    if (!rst_n) assert_reset_zero_R9: assert (binOut == '0 && !errOut);
  end

  generate
    if (PRIORITY) begin : g_prioChk
      // R7: empty word flagged
      assert_prio_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && act == '0) |=> errOut);
      // R5 R6: any active bit clears the error
      assert_prio_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && act != '0) |=> !errOut);
      if (MSB_FIRST) begin : g_msb
        assert_msb_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (enable && act[WIDTH-1]) |=> binOut == IDX_W'(WIDTH - 1));
      end else begin : g_lsb
        assert_lsb_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (enable && act[0]) |=> binOut == '0);
      end
    end else begin : g_flatChk
      // R3 R4: anything but exactly one active bit is flagged
      assert_flat_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $countones(act) != 1) |=> errOut);
    end
  endgenerate
endmodule

bind onehot_bin_enc onehot_bin_enc_sva #(
  .WIDTH       (WIDTH),
  .ACTIVE_HIGH (ACTIVE_HIGH),
  .PRIORITY    (PRIORITY),
  .MSB_FIRST   (MSB_FIRST)
) u_sva (
  .clk    (clk),
  .rst_n  (rst_n),
  .codeIn (codeIn),
  .enable (enable),
  .binOut (binOut),
  .errOut (errOut)
);

// File: tb/onehot_bin_enc_bench.sv
module onehot_bin_enc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 10;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] codeHi = '0;
  logic [W-1:0] codeLo = '1;
  logic [IW-1:0] bin0, bin1, bin2, bin3;
  logic err0, err1, err2, err3;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Variant 0: flat active-high (main instance)
  onehot_bin_enc #(.WIDTH(W), .ACTIVE_HIGH(1'b1), .PRIORITY(1'b0), .MSB_FIRST(1'b0)) u_onehot_bin_enc (
    .clk(clk), .rst_n(rst_n), .codeIn(codeHi), .enable(enable), .binOut(bin0), .errOut(err0));
  // Variant 1: flat active-low
  onehot_bin_enc #(.WIDTH(W), .ACTIVE_HIGH(1'b0), .PRIORITY(1'b0), .MSB_FIRST(1'b0)) u_onehot_bin_enc_low (
    .clk(clk), .rst_n(rst_n), .codeIn(codeLo), .enable(enable), .binOut(bin1), .errOut(err1));
  // Variant 2: priority LSB first, active-high
  onehot_bin_enc #(.WIDTH(W), .ACTIVE_HIGH(1'b1), .PRIORITY(1'b1), .MSB_FIRST(1'b0)) u_onehot_bin_enc_plsb (
    .clk(clk), .rst_n(rst_n), .codeIn(codeHi), .enable(enable), .binOut(bin2), .errOut(err2));
  // Variant 3: priority MSB first, active-low
  onehot_bin_enc #(.WIDTH(W), .ACTIVE_HIGH(1'b0), .PRIORITY(1'b1), .MSB_FIRST(1'b1)) u_onehot_bin_enc_pmsb (
    .clk(clk), .rst_n(rst_n), .codeIn(codeLo), .enable(enable), .binOut(bin3), .errOut(err3));

  typedef struct {
    logic [3:0][IW-1:0] idx;
    logic [3:0]         err;
    int                 cyc;
    string              tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int cycNum = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cycNum <= cycNum + 1;

  // Reference model per variant, from the requirements
  function automatic void model(input int v, input logic en, input logic [W-1:0] act,
                                output logic [IW-1:0] idx, output logic err);
    int cnt = 0;
    int lo = -1;
    int hi = -1;
    for (int i = 0; i < W; i++) begin
      if (act[i]) begin
        cnt++;
        if (lo < 0) lo = i;
        hi = i;
      end
    end
    idx = '0;
    err = 1'b0;
    if (!en) return;                   // R8
    if (v >= 2) begin
      if (cnt == 0) err = 1'b1;        // R7
      else idx = IW'((v == 3) ? hi : lo); // R5 R6
    end else begin
      if (cnt == 1) idx = IW'(lo);     // R1 R2
      else err = 1'b1;                 // R3 R4
    end
  endfunction

  // Driver: apply one logical pattern to all variants and queue the expectation
  task automatic drive(input logic en, input logic [W-1:0] act, input string tag);
    expItem_t it;
    @(negedge clk);
    enable = en;
    codeHi = act;
    codeLo = ~act;
    for (int v = 0; v < 4; v++) begin
      logic [IW-1:0] ei;
      logic ee;
      model(v, en, act, ei, ee);
      it.idx[v] = ei;
      it.err[v] = ee;
    end
    it.cyc = cycNum;
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  function automatic void cmp(input int v, input logic [IW-1:0] gi, input logic ge,
                              input expItem_t it);
    checks++;
    if (gi !== it.idx[v] || ge !== it.err[v]) begin
      errors++;
      $display("FAIL %s variant %0d: got idx=%0d err=%0b expected idx=%0d err=%0b",
               it.tag, v, gi, ge, it.idx[v], it.err[v]);
    end
  endfunction

  // Monitor: R10 one-edge latency, each item checked the negedge after its sampling edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0 && scoreQ[0].cyc < cycNum) begin
      expItem_t it;
      it = scoreQ.pop_front();
      cmp(0, bin0, err0, it);
      cmp(1, bin1, err1, it);
      cmp(2, bin2, err2, it);
      cmp(3, bin3, err3, it);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if ({bin0, bin1, bin2, bin3} !== '0 || {err0, err1, err2, err3} !== 4'b0) begin
      errors++;
      $display("FAIL R9: got %0d %0d %0d %0d errs %b expected all zero",
               bin0, bin1, bin2, bin3, {err0, err1, err2, err3});
    end
    rst_n = 1'b1;
    // R1 R2 R10: walk a single active bit over every position
    for (int k = 0; k < W; k++) drive(1'b1, W'(1) << k, "R1 R2 R10 single");
    // R3 R7: empty word
    drive(1'b1, '0, "R3 R7 empty");
    // R4 R5 R6: multi-bit words
    drive(1'b1, W'(10'b0000100100), "R4 R5 R6 multi");
    drive(1'b1, '1, "R4 R5 R6 all");
    drive(1'b1, W'(10'b1000000001), "R4 R5 R6 ends");
    drive(1'b1, W'(10'b0110000000), "R4 R5 R6 upper");
    // R8: disable after a valid and after an invalid word
    drive(1'b1, W'(10'b0000001000), "R1 before disable");
    drive(1'b0, W'(10'b0000001000), "R8 disabled valid");
    drive(1'b1, W'(10'b0000000011), "R4 before disable");
    drive(1'b0, W'(10'b0000000011), "R8 disabled multi");
    drive(1'b0, '0, "R8 disabled empty");
    drive(1'b1, W'(10'b0100000000), "R1 R2 reenable");
    repeat (3) @(negedge clk);
    // R10: queue must be drained
    checks++;
    if (scoreQ.size() != 0) begin
      errors++;
      $display("FAIL R10: got %0d pending results expected 0", scoreQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule